// File: doc/BRIEF.md
# Asynchronous Timer Interrupt Flag Controller

This block keeps the interrupt enable byte and the sticky interrupt flag byte for a group of timers. Two of the flags, compare-match and overflow, belong to an 8-bit timer whose counter runs on its own clock. Each of that timer's events flips a toggle in the timer clock domain. The processor clock domain passes the toggle through a two-flop synchronizer and an edge detector, so a single event sets its flag exactly once. The six lower flags belong to timers that run on the processor clock. Their set inputs are plain synchronous pulses.

Software writes the enable byte and the flag byte through a small write port. Writing a one to a flag bit clears that flag, and writing a zero leaves it as it is. Each flag can also be cleared by an acknowledge pulse when the processor takes the matching vector. An interrupt request line is high while the global enable, the enable bit and the flag are all one. In the phase-correct PWM setting, the overflow flag follows the counter's turn-around at zero instead of its wrap.

Top module: `tmr_irq_flags`

## Requirements
- R1: While reset is low, and on release from reset, the enable byte, the flag byte and all eight request lines read as zero. An event that was pending in either clock domain is dropped.
- R2: A write with `wr_sel`=0 stores `wr_data` in the enable byte at that clock edge. Reading with `rd_sel`=0 returns the enable byte.
- R3: A write with `wr_sel`=1 clears every flag whose `wr_data` bit is 1 and leaves every flag whose bit is 0 unchanged. Reading with `rd_sel`=1 returns the flag byte.
- R4: `lo_set[k]` high at a processor clock edge sets flag bit k (k = 0..5) at that edge.
- R5: `ack[i]` high at a processor clock edge clears flag bit i at that edge.
- R6: If a set and a clear (write-one or acknowledge) reach the same flag at the same edge, the flag ends up set. This holds for the synchronous and the asynchronous sources alike.
- R7: `irq[i]` is 1 exactly when `gie`, enable bit i and flag bit i are all 1. It follows combinationally from those three.
- R8: A compare-match pulse sampled by a rising `tclk` edge sets flag bit 7 at the third rising `clk` edge after that `tclk` edge.
- R9: With `pwm_mode`=0, a `t_wrap` pulse sets flag bit 6 with the R8 latency, and `t_turn` has no effect.
- R10: With `pwm_mode`=1, a `t_turn` pulse sets flag bit 6 with the R8 latency, and `t_wrap` has no effect.
- R11: Timer-domain events on consecutive `tclk` edges are each carried across once, as long as `tclk` is slower than `clk`. Two back-to-back compare events, with the flag acknowledged in between, make flag bit 7 rise twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| tclk | input | 1 | Asynchronous timer clock |
| t_cmp_match | input | 1 | Timer-domain compare-match pulse |
| t_wrap | input | 1 | Timer-domain counter wrap pulse |
| t_turn | input | 1 | Timer-domain turn-around at zero pulse (phase-correct PWM) |
| pwm_mode | input | 1 | 1 selects turn-around as the overflow source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 enable byte, 1 flag byte |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 enable byte, 1 flag byte |
| rd_data | output | 8 | Read data |
| gie | input | 1 | Global interrupt enable |
| lo_set | input | 6 | Synchronous set pulses for flag bits 5..0 |
| ack | input | 8 | Per-flag interrupt acknowledge |
| irq | output | 8 | Per-flag interrupt request |

## Verification
The hardest case to reach from the ports is an asynchronous event whose flag update lands on the same processor edge as a clear. The moment depends on the phase between the two clocks. The bench's reference model timestamps each sampled timer event with the processor edge on which it is due. A stimulus thread reads that timestamp and places an acknowledge, or a write-one-to-clear, on exactly that edge. Back-to-back timer events are driven under an automatic acknowledge, and the bench counts how many times the flag rises.

// File: rtl/tif_pkg.sv
package tif_pkg;

  localparam int unsigned TIF_REG_W   = 8;
  localparam int unsigned TIF_ASYNC_N = 2;
  localparam int unsigned TIF_LO_W    = TIF_REG_W - TIF_ASYNC_N;

  typedef logic [TIF_REG_W-1:0] tif_byte_t;

  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_FLAG = 1'b1
  } reg_sel_e;

  // Async event index 0 = compare match (top bit), 1 = overflow (next bit down).
  function automatic int unsigned async_bit(input int unsigned idx);
    return TIF_REG_W - 1 - idx;
  endfunction

  function automatic tif_byte_t w1c_mask(input logic en, input tif_byte_t data);
    return en ? data : '0;
  endfunction

  // Clear first, then set: a coincident set survives.
  function automatic tif_byte_t flag_next(input tif_byte_t cur, input tif_byte_t set,
                                          input tif_byte_t clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic tif_byte_t irq_gate(input logic g, input tif_byte_t en,
                                         input tif_byte_t fl);
    return g ? (en & fl) : '0;
  endfunction

endpackage

// File: rtl/tif_evt_toggle.sv
module tif_evt_toggle (
  input  logic tclk,
  input  logic rst_n,
  input  logic evt,
  output logic tog
);

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      tog <= 1'b0;
    end else if (evt) begin
      tog <= ~tog;
    end
  end

endmodule

// File: rtl/tif_evt_sync.sv
module tif_evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q[0] <= tog_in;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
      last_q <= chain_q[STAGES-1];
    end
  end

  assign pulse = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/tif_regs.sv
module tif_regs
  import tif_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      wr_sel,
  input  tif_byte_t wr_data,
  input  tif_byte_t set_vec,
  input  tif_byte_t ack,
  output tif_byte_t mask_q,
  output tif_byte_t flag_q,
  output tif_byte_t clr_vec
);

  logic flag_wr;
  logic mask_wr;

  assign flag_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_FLAG);
  assign mask_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK);
  assign clr_vec = w1c_mask(flag_wr, wr_data) | ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_wr) begin
      mask_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_next(flag_q, set_vec, clr_vec);
    end
  end

endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tif_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tclk,
  input  logic                    t_cmp_match,
  input  logic                    t_wrap,
  input  logic                    t_turn,
  input  logic                    pwm_mode,
  input  logic                    wr_en,
  input  logic                    wr_sel,
  input  logic [TIF_REG_W-1:0]    wr_data,
  input  logic                    rd_sel,
  output logic [TIF_REG_W-1:0]    rd_data,
  input  logic                    gie,
  input  logic [TIF_LO_W-1:0]     lo_set,
  input  logic [TIF_REG_W-1:0]    ack,
  output logic [TIF_REG_W-1:0]    irq
);

  localparam int unsigned ASYNC_N = TIF_ASYNC_N;
  localparam int unsigned LO_W    = TIF_LO_W;

  // Timer-domain event vector: 0 = compare match, 1 = overflow source.
  logic [ASYNC_N-1:0] t_evt;
  logic [ASYNC_N-1:0] t_tog;
  logic [ASYNC_N-1:0] sync_set;
  tif_byte_t          set_vec;
  tif_byte_t          clr_vec;
  tif_byte_t          mask_q;
  tif_byte_t          flag_q;

  assign t_evt[0] = t_cmp_match;
  assign t_evt[1] = pwm_mode ? t_turn : t_wrap;

  for (genvar g = 0; g < ASYNC_N; g++) begin : g_async
    tif_evt_toggle u_tog (
      .tclk (tclk),
      .rst_n(rst_n),
      .evt  (t_evt[g]),
      .tog  (t_tog[g])
    );

    tif_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .tog_in(t_tog[g]),
      .pulse (sync_set[g])
    );

    assign set_vec[async_bit(g)] = sync_set[g];
  end

  assign set_vec[LO_W-1:0] = lo_set;

  tif_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .set_vec(set_vec),
    .ack    (ack),
    .mask_q (mask_q),
    .flag_q (flag_q),
    .clr_vec(clr_vec)
  );

  assign rd_data = (reg_sel_e'(rd_sel) == SEL_FLAG) ? flag_q : mask_q;
  assign irq     = irq_gate(gie, mask_q, flag_q);

endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk
  import tif_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   gie,
  input logic                   wr_en,
  input logic                   wr_sel,
  input logic [TIF_REG_W-1:0]   wr_data,
  input logic [TIF_REG_W-1:0]   ack,
  input logic [TIF_REG_W-1:0]   irq,
  input logic [TIF_REG_W-1:0]   set_vec,
  input logic [TIF_REG_W-1:0]   clr_vec,
  input logic [TIF_REG_W-1:0]   mask_q,
  input logic [TIF_REG_W-1:0]   flag_q,
  input logic [TIF_ASYNC_N-1:0] sync_set
);

  a_r2_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (mask_q == $past(wr_data)));

  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> ((flag_q & $past(wr_data) & ~$past(set_vec)) == '0));

  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0 && set_vec == '0) |=> (flag_q == $past(flag_q)));

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |=> ((flag_q & $past(ack) & ~$past(set_vec)) == '0));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  a_r7_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> gie);

  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~flag_q) == '0));

  a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~mask_q) == '0));

  // R11: each crossing produces a one-cycle pulse only (tclk slower than clk).
  a_r11_single_cmp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sync_set[0] |=> !sync_set[0]);

  a_r11_single_ovf_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sync_set[1] |=> !sync_set[1]);

endmodule

bind tmr_irq_flags tmr_irq_flags_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gie     (gie),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .ack     (ack),
  .irq     (irq),
  .set_vec (set_vec),
  .clr_vec (clr_vec),
  .mask_q  (mask_q),
  .flag_q  (flag_q),
  .sync_set(sync_set)
);

// File: tb/tmr_irq_flags_test.sv
module tmr_irq_flags_test;

  localparam int CLK_P  = 10;
  localparam int TCLK_H = 13;

  logic       clk = 1'b0;
  logic       tclk = 1'b0;
  logic       rst_n = 1'b1;
  logic       t_cmp_match = 1'b0, t_wrap = 1'b0, t_turn = 1'b0, pwm_mode = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, gie = 1'b0;
  logic [7:0] wr_data = '0, ack = '0, rd_data, irq;
  logic [5:0] lo_set = '0;

  tmr_irq_flags uut (
    .clk(clk), .rst_n(rst_n), .tclk(tclk), .t_cmp_match(t_cmp_match),
    .t_wrap(t_wrap), .t_turn(t_turn), .pwm_mode(pwm_mode), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .gie(gie), .lo_set(lo_set), .ack(ack), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;
  initial begin
    #12 tclk = 1'b1;
    forever #TCLK_H tclk = ~tclk;
  end

  int          checks = 0;
  int          errors = 0;
  string       cur_req = "R1";
  logic        g_en = 1'b0;
  logic [7:0]  auto_ack = '0;
  int          rise7 = 0;
  logic        prev7 = 1'b0;

  // Behavioural reference model
  int unsigned edge_n = 0;
  int unsigned due_cmp[$];
  int unsigned due_ovf[$];
  logic [7:0]  m_mask = '0;
  logic [7:0]  m_flag = '0;

  always @(posedge tclk) begin
    if (rst_n) begin
      if (t_cmp_match) due_cmp.push_back(edge_n + 3);
      if (pwm_mode ? t_turn : t_wrap) due_ovf.push_back(edge_n + 3);
    end
  end

  always @(posedge clk) begin
    logic [7:0] s, c;
    edge_n++;
    if (!rst_n) begin
      m_mask = '0; m_flag = '0;
      due_cmp.delete(); due_ovf.delete();
    end else begin
      s = {2'b00, lo_set};
      if (due_cmp.size() != 0 && due_cmp[0] == edge_n) begin
        void'(due_cmp.pop_front()); s[7] = 1'b1;
      end
      if (due_ovf.size() != 0 && due_ovf[0] == edge_n) begin
        void'(due_ovf.pop_front()); s[6] = 1'b1;
      end
      c = ack | ((wr_en && wr_sel) ? wr_data : 8'h00);
      for (int i = 0; i < 8; i++) begin
        if (s[i]) m_flag[i] = 1'b1;
        else if (c[i]) m_flag[i] = 1'b0;
      end
      if (wr_en && !wr_sel) m_mask = wr_data;
    end
  end

  task automatic check8(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // Compare on every clock, away from the edge.
  always @(negedge clk) begin
    logic [7:0] e_irq;
    rd_sel = 1'b0;
    #1 check8("enable byte", rd_data, m_mask);
    rd_sel = 1'b1;
    #1 check8("flag byte", rd_data, m_flag);
    e_irq = 8'h00;
    for (int i = 0; i < 8; i++) e_irq[i] = gie & m_mask[i] & m_flag[i];
    check8("irq", irq, e_irq);
    if (rd_data[7] && !prev7) rise7++;
    prev7 = rd_data[7];
  end

  task automatic cyc(input logic we, input logic ws, input logic [7:0] wd,
                     input logic [5:0] ls, input logic [7:0] ak);
    @(negedge clk); #3;
    wr_en = we; wr_sel = ws; wr_data = wd; lo_set = ls;
    ack = ak | (auto_ack & m_flag); gie = g_en;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, 6'h00, 8'h00);
  endtask

  // sel: 0 compare match, 1 wrap, 2 turn; held for n tclk rising edges
  task automatic tburst(input int sel, input int n);
    @(negedge tclk);
    if (sel == 0) t_cmp_match = 1'b1;
    else if (sel == 1) t_wrap = 1'b1;
    else t_turn = 1'b1;
    for (int i = 0; i < n; i++) @(negedge tclk);
    t_cmp_match = 1'b0; t_wrap = 1'b0; t_turn = 1'b0;
  endtask

  task automatic clear_on_edge(input int unsigned target, input logic by_write);
    do @(negedge clk); while (edge_n + 1 < target);
    #3;
    if (by_write) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h80; end
    else ack = 8'h80;
  endtask

  task automatic aligned_clear(input logic by_write);
    int unsigned tgt;
    fork
      tburst(0, 1);
      begin
        while (due_cmp.size() == 0) begin @(posedge tclk); #1; end
        tgt = due_cmp[0];
        clear_on_edge(tgt, by_write);
      end
    join
    idle(1);
    checks++;
    if (m_flag[7] !== 1'b1) begin
      errors++;
      $display("FAIL R6 aligned clear actual=%b expected=1", m_flag[7]);
    end
    idle(4);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    cur_req = "R1";
    repeat (4) @(negedge clk);
    #3 rst_n = 1'b1;
    idle(2);

    cur_req = "R2";
    cyc(1, 0, 8'hA5, 0, 0); cyc(1, 0, 8'h5A, 0, 0); cyc(1, 0, 8'hFF, 0, 0); idle(1);

    cur_req = "R4";
    cyc(0, 0, 0, 6'h15, 0); cyc(0, 0, 0, 6'h2A, 0); idle(1);

    cur_req = "R3";
    cyc(1, 1, 8'h00, 0, 0); cyc(1, 1, 8'h05, 0, 0); idle(1);
    cyc(1, 1, 8'hFF, 0, 0); idle(1);

    cur_req = "R5";
    cyc(0, 0, 0, 6'h3F, 0); cyc(0, 0, 0, 0, 8'h09); cyc(0, 0, 0, 0, 8'h36); idle(1);

    cur_req = "R6";
    cyc(0, 0, 0, 6'h01, 0); cyc(1, 1, 8'h01, 6'h01, 0); cyc(0, 0, 0, 6'h02, 8'h03);
    idle(1);

    cur_req = "R7";
    cyc(0, 0, 0, 6'h3F, 0); idle(1);
    g_en = 1'b1; idle(2);
    cyc(1, 0, 8'h0F, 0, 0); idle(1);
    g_en = 1'b0; idle(1);
    g_en = 1'b1; cyc(1, 1, 8'hFF, 0, 0); cyc(1, 0, 8'hFF, 0, 0); idle(1);

    cur_req = "R8";
    fork tburst(0, 1); idle(8); join
    cyc(1, 1, 8'h80, 0, 0); idle(2);

    cur_req = "R9";
    pwm_mode = 1'b0;
    fork tburst(1, 1); idle(8); join
    cyc(0, 0, 0, 0, 8'h40);
    fork tburst(2, 1); idle(8); join

    cur_req = "R10";
    pwm_mode = 1'b1;
    fork tburst(2, 1); idle(8); join
    cyc(0, 0, 0, 0, 8'h40);
    fork tburst(1, 1); idle(8); join
    pwm_mode = 1'b0;

    cur_req = "R6";
    aligned_clear(1'b0);
    cyc(0, 0, 0, 0, 8'h80); idle(1);
    aligned_clear(1'b1);
    cyc(0, 0, 0, 0, 8'h80); idle(2);

    cur_req = "R11";
    rise7 = 0;
    auto_ack = 8'h80;
    fork tburst(0, 2); idle(14); join
    auto_ack = 8'h00;
    idle(2);
    checks++;
    if (rise7 != 2) begin
      errors++;
      $display("FAIL R11 flag7 rises actual=%0d expected=2", rise7);
    end

    cur_req = "R1";
    cyc(1, 0, 8'hC3, 6'h3F, 0);
    fork tburst(0, 1); idle(2); join
    @(negedge clk); #3 rst_n = 1'b0;
    idle(3);
    @(negedge clk); #3 rst_n = 1'b1;
    idle(8);

    finish_run();
  end

endmodule